// File: doc/BRIEF.md
# SDRAM Command Bus Bank Timing Monitor

This block watches the command pins of a four-bank synchronous DRAM and reports protocol mistakes made by the controller that drives them. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, the bank field and the address bit that means "all banks" or "auto-precharge". It decodes one command per cycle and keeps, for each bank, whether a row is open and how long ago the bank was last opened and closed. A command that breaks a state rule or a minimum spacing raises a one-cycle error strobe with a code and the bank field it carried.

Auto-precharge is modelled in full. While a burst with auto-precharge is running, no other read, write or precharge is legal. The bank then closes by itself at the end of the burst. After a read it may be reopened one precharge time later. After a write it must also wait the write recovery time, counted from the last data-in cycle. The burst length used for this timing comes from two side inputs that mirror the programmed mode. All limits are parameters in clock cycles. The default limits suit a 7.5 ns clock.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command counts only when cs_n is low. With cke low, only the refresh code is decoded, and any other code is ignored. Deselect, no-op and burst stop never raise an error.
- R2: A read or write to a bank that is not open gives code 1 (bank not open).
- R3: A read or write that comes fewer than T_RCD cycles after that bank's activate gives code 3 (spacing).
- R4: An activate to a bank that is already open gives code 2 (already open).
- R5: An activate gives code 3 in three cases: it comes fewer than T_RRD cycles after any accepted activate; it comes fewer than T_RC cycles after the last activate of the same bank; or it comes fewer than T_RP cycles after that bank was closed.
- R6: A precharge with a10 high closes every open bank. With a10 low it closes only the bank named by ba. If any bank it would close has been open for fewer than T_RAS cycles, it gives code 3 and closes nothing. A precharge of a closed bank has no effect.
- R7: A read or write with a10 high, issued at cycle t with burst length BL = 2^bl_log2, makes every read, write or precharge in cycles t+1 to t+BL-1 give code 4 (auto-precharge busy).
- R8: That bank closes at cycle t+BL. After a read, activate becomes legal at cycle t+BL+T_RP. After a write, it becomes legal at cycle t+BL-1+T_DPL+T_RP.
- R9: A read or write with a10 high while full_page is high gives code 5 (auto-precharge on full page).
- R10: Refresh with cke high or low, and mode register set, give code 6 (not idle) while any bank is open.
- R11: The error outputs are registered. err_valid rises in the cycle after the edge that sampled the bad command. err_code is 0 exactly when err_valid is low. err_bank repeats the command's ba and is 0 when there is no error. A flagged command changes no tracked state.
- R12: Only one code is given per command. Code 4 comes first, then the state codes 1, 2, 5 and 6, then code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank field of the command |
| a10 | input | 1 | All-banks flag on precharge, auto-precharge flag on read/write |
| bl_log2 | input | 2 | Programmed burst length as a power of two (0 to 3 for 1 to 8) |
| full_page | input | 1 | High when full-page bursts are programmed |
| err_valid | output | 1 | One-cycle strobe for a rule violation |
| err_code | output | 3 | Violation code (0 none, 1 to 6 as in the requirements) |
| err_bank | output | 2 | ba of the offending command |

## Verification
A verdict for the command sampled at edge n appears on the outputs just after that edge and stays for one cycle. The bench therefore drives each command on a falling edge and runs its own behavioural model for that cycle number. It then compares all three outputs on the next falling edge, one comparison per cycle. All auto-precharge windows are kept in the model as absolute cycle numbers (busy until t+BL-1, closed at t+BL, reopenable at the computed cycle). The directed scenarios probe the cycle just before and the cycle at each window edge. A long pseudo-random phase then compares the monitor against the model on every cycle.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5,
    CMD_REF = 3'd6,
    CMD_MRS = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_NOT_OPEN     = 3'd1,
    ERR_ALREADY_OPEN = 3'd2,
    ERR_SPACING      = 3'd3,
    ERR_AP_BUSY      = 3'd4,
    ERR_AP_FULLPAGE  = 3'd5,
    ERR_NOT_IDLE     = 3'd6
  } err_e;

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
  import sdmon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd
);
  cmd_e raw;

  always_comb begin
    unique case ({ras_n, cas_n, we_n})
      3'b011:  raw = CMD_ACT;
      3'b101:  raw = CMD_RD;
      3'b100:  raw = CMD_WR;
      3'b010:  raw = CMD_PRE;
      3'b110:  raw = CMD_BST;
      3'b001:  raw = CMD_REF;
      3'b000:  raw = CMD_MRS;
      default: raw = CMD_NOP;
    endcase
    if (cs_n)
      cmd = CMD_NOP;
    else if (!cke && raw != CMD_REF)
      cmd = CMD_NOP;   // power-down / suspend: only refresh (self refresh) counts
    else
      cmd = raw;
  end
endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  parameter int T_RAS = 6,
  parameter int T_DPL = 2,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             ap_go,
  input  logic             ap_wr,
  input  logic [LEN_W-1:0] ap_len,
  output logic             is_open,
  output logic             rcd_met,
  output logic             ras_met,
  output logic             rc_met,
  output logic             rp_met,
  output logic             ap_run
);
  localparam int SAT0 = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int SAT  = (T_RC > SAT0) ? T_RC : SAT0;
  localparam int SW   = $clog2(SAT + 1);
  localparam int BMAX = (T_DPL + T_RP > T_RP) ? (T_DPL + T_RP) : T_RP;
  localparam int BW   = $clog2(BMAX + 1);

  logic             open_q;
  logic [SW-1:0]    since_q;
  logic [BW-1:0]    block_q;
  logic [LEN_W-1:0] left_q;
  logic             wr_q;
  logic             close_now;
  logic             wr_sel;
  logic [BW-1:0]    close_val;

  // bank closes itself when the last burst beat is sampled
  assign close_now = (ap_go && ap_len == LEN_W'(1)) || (!ap_go && left_q == LEN_W'(1));
  assign wr_sel    = ap_go ? ap_wr : wr_q;
  assign close_val = wr_sel ? BW'(T_DPL + T_RP - 1) : BW'(T_RP);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      since_q <= SW'(SAT);
      block_q <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      if (act_go)
        since_q <= SW'(1);
      else if (since_q != SW'(SAT))
        since_q <= since_q + SW'(1);

      if (pre_go)
        block_q <= BW'(T_RP - 1);
      else if (close_now)
        block_q <= close_val;
      else if (block_q != '0)
        block_q <= block_q - BW'(1);

      if (act_go)
        open_q <= 1'b1;
      else if (pre_go || close_now)
        open_q <= 1'b0;

      if (ap_go) begin
        left_q <= ap_len - LEN_W'(1);
        wr_q   <= ap_wr;
      end else if (left_q != '0) begin
        left_q <= left_q - LEN_W'(1);
      end
    end
  end

  assign is_open = open_q;
  assign rcd_met = since_q >= SW'(T_RCD);
  assign ras_met = since_q >= SW'(T_RAS);
  assign rc_met  = since_q >= SW'(T_RC);
  assign rp_met  = block_q == '0;
  assign ap_run  = left_q != '0;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  parameter int T_RRD = 2,
  parameter int T_RAS = 6,
  parameter int T_DPL = 2,
  localparam int BA_W = $clog2(NBANK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic [1:0]      bl_log2,
  input  logic            full_page,
  output logic            err_valid,
  output logic [2:0]      err_code,
  output logic [BA_W-1:0] err_bank
);
  localparam int LEN_W = 4;
  localparam int RW    = $clog2(T_RRD + 1);

  cmd_e             cmd;
  err_e             verdict;
  logic [NBANK-1:0] bank_open, rcd_ok, ras_ok, rc_ok, rp_ok, ap_run;
  logic [NBANK-1:0] act_go, pre_go, ap_go, sel;
  logic             ap_busy;
  logic [LEN_W-1:0] bl_val;
  logic [RW-1:0]    rrd_q;
  logic             rrd_ok;

  sdmon_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cke  (cke),
    .cmd  (cmd)
  );

  assign sel     = NBANK'(1) << ba;
  assign ap_busy = |ap_run;
  assign bl_val  = LEN_W'(1) << bl_log2;
  assign rrd_ok  = rrd_q >= RW'(T_RRD);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdmon_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
      .T_RAS(T_RAS), .T_DPL(T_DPL), .LEN_W(LEN_W)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .act_go (act_go[g]),
      .pre_go (pre_go[g]),
      .ap_go  (ap_go[g]),
      .ap_wr  (cmd == CMD_WR),
      .ap_len (bl_val),
      .is_open(bank_open[g]),
      .rcd_met(rcd_ok[g]),
      .ras_met(ras_ok[g]),
      .rc_met (rc_ok[g]),
      .rp_met (rp_ok[g]),
      .ap_run (ap_run[g])
    );
  end

  // verdict and state strobes; a flagged command moves no state
  always_comb begin
    verdict = ERR_NONE;
    act_go  = '0;
    pre_go  = '0;
    ap_go   = '0;
    unique case (cmd)
      CMD_REF, CMD_MRS: begin
        if (|bank_open) verdict = ERR_NOT_IDLE;
      end
      CMD_RD, CMD_WR: begin
        if (ap_busy)                 verdict = ERR_AP_BUSY;
        else if (!bank_open[ba])     verdict = ERR_NOT_OPEN;
        else if (a10 && full_page)   verdict = ERR_AP_FULLPAGE;
        else if (!rcd_ok[ba])        verdict = ERR_SPACING;
        else if (a10)                ap_go   = sel;
      end
      CMD_PRE: begin
        if (ap_busy)
          verdict = ERR_AP_BUSY;
        else if (a10) begin
          if (|(bank_open & ~ras_ok)) verdict = ERR_SPACING;
          else                        pre_go  = bank_open;
        end else begin
          if (bank_open[ba] && !ras_ok[ba]) verdict = ERR_SPACING;
          else                              pre_go  = sel & bank_open;
        end
      end
      CMD_ACT: begin
        if (bank_open[ba])                              verdict = ERR_ALREADY_OPEN;
        else if (!rp_ok[ba] || !rc_ok[ba] || !rrd_ok)   verdict = ERR_SPACING;
        else                                            act_go  = sel;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q     <= RW'(T_RRD);
      err_valid <= 1'b0;
      err_code  <= 3'd0;
      err_bank  <= '0;
    end else begin
      if (|act_go)
        rrd_q <= RW'(1);
      else if (!rrd_ok)
        rrd_q <= rrd_q + RW'(1);
      err_valid <= verdict != ERR_NONE;
      err_code  <= verdict;
      err_bank  <= (verdict != ERR_NONE) ? ba : '0;
    end
  end
endmodule

// File: rtl/sdmon_sva.sv
module sdmon_sva #(
  parameter int BA_W = 2,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             cke,
  input logic [BA_W-1:0]  ba,
  input logic             a10,
  input logic             full_page,
  input logic [NBANK-1:0] bank_open,
  input logic             ap_busy,
  input logic             err_valid,
  input logic [2:0]       err_code
);
  logic is_rdwr, is_act, is_ref;
  assign is_rdwr = !cs_n && cke && ras_n && !cas_n;
  assign is_act  = !cs_n && cke && !ras_n && cas_n && we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n && we_n;

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !err_valid);

  assert_closed_bank_R2: assert property (@(posedge clk) disable iff (rst)
    is_rdwr && !ap_busy && !bank_open[ba] |=> err_valid && err_code == 3'd1);

  assert_reopen_R4: assert property (@(posedge clk) disable iff (rst)
    is_act && bank_open[ba] |=> err_valid && err_code == 3'd2);

  assert_ap_busy_R7: assert property (@(posedge clk) disable iff (rst)
    is_rdwr && ap_busy |=> err_valid && err_code == 3'd4);

  assert_fullpage_R9: assert property (@(posedge clk) disable iff (rst)
    is_rdwr && a10 && full_page && !ap_busy && bank_open[ba]
      |=> err_valid && err_code == 3'd5);

  assert_refresh_idle_R10: assert property (@(posedge clk) disable iff (rst)
    is_ref && (|bank_open) |=> err_valid && err_code == 3'd6);

  assert_code_match_R11: assert property (@(posedge clk) disable iff (rst)
    err_valid == (err_code != 3'd0));
endmodule

bind sdram_cmd_monitor sdmon_sva #(.BA_W(BA_W), .NBANK(NBANK)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .cke      (cke),
  .ba       (ba),
  .a10      (a10),
  .full_page(full_page),
  .bank_open(bank_open),
  .ap_busy  (ap_busy),
  .err_valid(err_valid),
  .err_code (err_code)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  localparam int TRCD = 3, TRP = 3, TRC = 9, TRRD = 2, TRAS = 6, TDPL = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0, bl_log2 = '0;
  logic a10 = 1'b0, full_page = 1'b0;
  logic err_valid;
  logic [2:0] err_code;
  logic [1:0] err_bank;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC), .T_RRD(TRRD),
                      .T_RAS(TRAS), .T_DPL(TDPL)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .a10(a10), .bl_log2(bl_log2), .full_page(full_page),
    .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank));

  int n_total = 0, n_bad = 0, cyc = 0;
  string tag = "R11";
  bit done = 0;

  // reference model: absolute cycle numbers
  int m_open[4], m_act_t[4], m_act_ok[4], m_close_t[4];
  int m_busy_to, m_any_act;

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      m_open[k] = 0; m_act_t[k] = -1000; m_act_ok[k] = 0; m_close_t[k] = -1;
    end
    m_busy_to = -1; m_any_act = -1000;
  endtask

  task automatic model_eval(output int e);
    int kind, b, bl, any_open, bad_ras;
    b = int'(ba); bl = 1 << bl_log2; e = 0;
    for (int k = 0; k < 4; k++)
      if (m_close_t[k] >= 0 && cyc >= m_close_t[k]) begin
        m_open[k] = 0; m_close_t[k] = -1;
      end
    any_open = 0; bad_ras = 0;
    for (int k = 0; k < 4; k++) begin
      if (m_open[k] != 0) any_open = 1;
      if (m_open[k] != 0 && cyc - m_act_t[k] < TRAS) bad_ras = 1;
    end
    case ({ras_n, cas_n, we_n})
      3'b011: kind = 1; 3'b101: kind = 2; 3'b100: kind = 3; 3'b010: kind = 4;
      3'b110: kind = 5; 3'b001: kind = 6; 3'b000: kind = 7; default: kind = 0;
    endcase
    if (cs_n) kind = 0;
    if (!cke && kind != 6) kind = 0;
    case (kind)
      6, 7: if (any_open != 0) e = 6;
      2, 3: begin
        if (cyc <= m_busy_to) e = 4;
        else if (m_open[b] == 0) e = 1;
        else if (a10 && full_page) e = 5;
        else if (cyc - m_act_t[b] < TRCD) e = 3;
        else if (a10) begin
          m_close_t[b] = cyc + bl;
          m_act_ok[b] = (kind == 2) ? cyc + bl + TRP : cyc + bl - 1 + TDPL + TRP;
          m_busy_to = cyc + bl - 1;
        end
      end
      4: begin
        if (cyc <= m_busy_to) e = 4;
        else if (a10) begin
          if (bad_ras != 0) e = 3;
          else for (int k = 0; k < 4; k++)
            if (m_open[k] != 0) begin m_open[k] = 0; m_act_ok[k] = cyc + TRP; end
        end else begin
          if (m_open[b] != 0 && cyc - m_act_t[b] < TRAS) e = 3;
          else if (m_open[b] != 0) begin m_open[b] = 0; m_act_ok[b] = cyc + TRP; end
        end
      end
      1: begin
        if (m_open[b] != 0) e = 2;
        else if (cyc < m_act_ok[b] || cyc - m_act_t[b] < TRC || cyc - m_any_act < TRRD) e = 3;
        else begin m_open[b] = 1; m_act_t[b] = cyc; m_any_act = cyc; end
      end
      default: ;
    endcase
  endtask

  function automatic string code_req(int c);
    case (c)
      1: return "R2"; 2: return "R4"; 3: return "R5"; 4: return "R7";
      5: return "R9"; 6: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input int e, input int b);
    bit ok;
    n_total++;
    ok = (err_valid === (e != 0)) && (err_code === 3'(e)) &&
         (err_bank === ((e != 0) ? 2'(b) : 2'd0));
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc=%0d: got valid=%b code=%0d bank=%0d, expected code=%0d bank=%0d",
               tag, cyc, err_valid, err_code, err_bank, e, (e != 0) ? b : 0);
    end
  endtask

  // drive on falling edge, model this cycle, compare one cycle later
  task automatic issue(input bit c_cs, input bit [2:0] rcw, input bit c_cke,
                       input int b, input bit c_a10);
    int e;
    cs_n = c_cs; {ras_n, cas_n, we_n} = rcw; cke = c_cke; ba = 2'(b); a10 = c_a10;
    model_eval(e);
    @(posedge clk);
    @(negedge clk);
    check(e, b);
    cyc++;
  endtask

  localparam bit [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                       C_BST = 3'b110, C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111;

  task automatic nop(input int k);
    for (int i = 0; i < k; i++) issue(1'b0, C_NOP, 1'b1, 0, 1'b0);
  endtask
  task automatic cmd(input bit [2:0] c, input int b, input bit f);
    issue(1'b0, c, 1'b1, b, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: outputs idle after reset
    n_total++;
    if (err_valid !== 1'b0 || err_code !== 3'd0 || err_bank !== 2'd0) begin
      n_bad++;
      $display("FAIL R11 reset: got valid=%b code=%0d expected 0", err_valid, err_code);
    end

    tag = "R2";  cmd(C_RD, 0, 0);                 // closed bank
    tag = "R5";  cmd(C_ACT, 0, 0); cmd(C_ACT, 1, 0); // second too soon (tRRD)
    nop(1);      cmd(C_ACT, 1, 0);
    tag = "R3";  cmd(C_RD, 1, 0);                 // before tRCD
    tag = "R4";  cmd(C_ACT, 0, 0);                // bank already open
    tag = "R6";  cmd(C_PRE, 1, 0);                // before tRAS
    nop(6);      cmd(C_PRE, 0, 1);                // all banks
    tag = "R5";  cmd(C_ACT, 0, 0);                // inside tRP
    nop(2);      cmd(C_ACT, 0, 0);
    tag = "R10"; cmd(C_REF, 0, 0);
    issue(1'b0, C_REF, 1'b0, 0, 1'b0);            // self refresh entry while open
    cmd(C_MRS, 0, 0);
    nop(6);      cmd(C_PRE, 0, 1); nop(3); cmd(C_REF, 0, 0); cmd(C_MRS, 0, 0);
    tag = "R1";  issue(1'b0, C_RD, 1'b0, 2, 1'b0); // cke low: ignored
    issue(1'b1, C_ACT, 1'b1, 0, 1'b0);             // deselect
    cmd(C_BST, 3, 0);
    tag = "R9";  cmd(C_ACT, 2, 0); nop(3);
    full_page = 1'b1; cmd(C_RD, 2, 1); full_page = 1'b0;
    tag = "R7";  bl_log2 = 2'd2; cmd(C_RD, 2, 1);   // read AP, BL4
    cmd(C_WR, 3, 0); cmd(C_PRE, 2, 0); nop(1);
    tag = "R8";  cmd(C_ACT, 2, 0); nop(2); cmd(C_ACT, 2, 0);
    nop(3);      bl_log2 = 2'd1; cmd(C_WR, 2, 1);    // write AP, BL2
    tag = "R7";  cmd(C_RD, 2, 0);
    tag = "R8";  nop(3); cmd(C_ACT, 2, 0); cmd(C_ACT, 2, 0);
    tag = "R12"; nop(3); bl_log2 = 2'd0; cmd(C_RD, 2, 1); // BL1 AP
    cmd(C_ACT, 2, 0); nop(2); cmd(C_ACT, 2, 0);

    // pseudo-random sweep, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int r, e;
      bit [2:0] c;
      r = $urandom_range(0, 99);
      if (r < 30) c = C_NOP; else if (r < 50) c = C_ACT; else if (r < 65) c = C_RD;
      else if (r < 78) c = C_WR; else if (r < 92) c = C_PRE; else if (r < 95) c = C_REF;
      else if (r < 97) c = C_MRS; else c = C_BST;
      bl_log2 = 2'($urandom_range(0, 3));
      full_page = ($urandom_range(0, 19) == 0);
      cs_n = ($urandom_range(0, 9) == 0); {ras_n, cas_n, we_n} = c;
      cke = ($urandom_range(0, 19) != 0);
      ba = 2'($urandom_range(0, 3)); a10 = ($urandom_range(0, 9) < 3);
      model_eval(e);
      tag = code_req(e);
      @(posedge clk); @(negedge clk);
      check(e, int'(ba));
      cyc++;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule